// File: doc/BRIEF.md
# Standby Cache Wake Hold Controller

This controller sits between a first-level cache and the peripheral circuits of a second-level cache. It keeps those circuits in a low-leakage standby state by default. A miss request from the first-level side starts a wake-up. The request is held until the wake-up is over, and only then is it passed on to the cache.

Every accepted request goes into a small in-order buffer that belongs to the controller. Requests that arrive while the cache sleeps or is still waking wait there. Once the cache is awake they drain one per cycle, in arrival order. After the last piece of work, the cache stays awake for a programmable number of idle cycles, so a cluster of misses does not pay the wake-up cost again and again. It then returns to standby.

The wake-up length is a programmable cycle count. If the power circuits report completion earlier on the wake-done input, the wake-up ends at that point instead.

Top module: `sb_wake_ctrl`

## Requirements
- R1: After reset, `sleep` is 1, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted while `sleep` is 1 makes `sleep` go to 0 in the next cycle.
- R3: When a request is accepted in standby at cycle c, `out_valid` first rises at cycle c+max(`cfg_wake`,1)+1. A `cfg_wake` of 0 behaves like 1.
- R4: If `wake_done` is 1 during a waking cycle, the cache is awake in the next cycle, whatever the remaining count.
- R5: `out_valid` is never 1 while the cache sleeps or is still waking.
- R6: A cycle counts as an activity cycle when it accepts a request or the buffer is non-empty. After the last activity cycle a, `sleep` rises at cycle a+max(`cfg_hold`,1)+1.
- R7: A request accepted during the keep-awake window restarts the window. It is offered at `out_valid` in the next cycle, with no new wake-up.
- R8: Requests leave on `out_data` in the order they were accepted.
- R9: With DEPTH entries held (4 by default), `in_ready` is 0. A request held off this way is accepted later and is not lost.
- R10: While the buffer holds any entry, `sleep` stays 0, however long `out_ready` is held low.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wake | input | CW | Wake-up length in cycles |
| cfg_hold | input | CW | Keep-awake idle cycles after the last activity |
| wake_done | input | 1 | Power-up complete indication, ends waking early |
| in_valid | input | 1 | Miss request valid from the first-level cache |
| in_ready | output | 1 | Buffer can take a request |
| in_data | input | DW | Request payload |
| out_valid | output | 1 | Request offered to the awake cache |
| out_ready | input | 1 | Cache takes the offered request |
| out_data | output | DW | Payload toward the cache |
| sleep | output | 1 | 1 puts the cache peripherals in standby |

## Verification
The bench counts the exact cycle of the first `out_valid` after a wake for a long count, for a zero count and for an early `wake_done`. An off-by-one in the wake counter shows up as an early or late offer, and a design that ignores `wake_done` waits out the full count. The keep-awake window is measured with a hold of zero and with a hold that a second request restarts. A controller that does not reload the window drops into standby in the middle of a burst. A burst that overfills the buffer while the cache refuses requests for longer than the hold period catches three faults: re-entering standby with work queued, losing the held request, and delivering requests out of order.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_AWAKE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/sbw_fifo.sv
module sbw_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [NW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [NW-1:0] count_n;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (push) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (push && !pop)      count_n = count + 1'b1;
    else if (pop && !push) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (count == NW'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/sbw_pwr_ctrl.sv
module sbw_pwr_ctrl
  import sbw_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_wake,
  input  logic [CW-1:0] cfg_hold,
  input  logic          wake_done,
  input  logic          accept,
  input  logic          q_busy,
  output logic          sleep,
  output logic          awake
);
  pwr_state_e    state, state_n;
  logic [CW-1:0] wcnt, wcnt_n;
  logic [CW-1:0] hcnt, hcnt_n;
  logic          wcnt_en, hcnt_en;

  always_comb begin
    state_n = state;
    wcnt_n  = wcnt;
    hcnt_n  = hcnt;
    wcnt_en = 1'b0;
    hcnt_en = 1'b0;
    unique case (state)
      ST_SLEEP: begin
        if (accept) begin
          state_n = ST_WAKE;
          wcnt_n  = cfg_wake;
          wcnt_en = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wake_done || (wcnt <= CW'(1))) begin
          state_n = ST_AWAKE;
          hcnt_n  = cfg_hold;
          hcnt_en = 1'b1;
        end else begin
          wcnt_n  = wcnt - 1'b1;
          wcnt_en = 1'b1;
        end
      end
      ST_AWAKE: begin
        if (accept || q_busy) begin
          hcnt_n  = cfg_hold;
          hcnt_en = 1'b1;
        end else if (hcnt <= CW'(1)) begin
          state_n = ST_SLEEP;
        end else begin
          hcnt_n  = hcnt - 1'b1;
          hcnt_en = 1'b1;
        end
      end
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SLEEP;
      wcnt  <= '0;
      hcnt  <= '0;
    end else begin
      state <= state_n;
      if (wcnt_en) wcnt <= wcnt_n;
      if (hcnt_en) hcnt <= hcnt_n;
    end
  end

  assign sleep = (state == ST_SLEEP);
  assign awake = (state == ST_AWAKE);
endmodule

// File: rtl/sb_wake_ctrl.sv
module sb_wake_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 8,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_wake,
  input  logic [CW-1:0] cfg_hold,
  input  logic          wake_done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          sleep
);
  logic          q_full, q_empty, awake;
  logic          accept, drain;
  logic [NW-1:0] q_cnt;

  assign in_ready  = !q_full;
  assign accept    = in_valid && in_ready;
  assign out_valid = awake && !q_empty;
  assign drain     = out_valid && out_ready;

  sbw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_data),
    .pop       (drain),
    .pop_data  (out_data),
    .count     (q_cnt),
    .full      (q_full),
    .empty     (q_empty)
  );

  sbw_pwr_ctrl #(.CW(CW)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wake  (cfg_wake),
    .cfg_hold  (cfg_hold),
    .wake_done (wake_done),
    .accept    (accept),
    .q_busy    (!q_empty),
    .sleep     (sleep),
    .awake     (awake)
  );
endmodule

// File: rtl/sb_wake_ctrl_chk.sv
module sb_wake_ctrl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [NW-1:0] q_cnt
);
  // R5
  no_out_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sleep);

  // R3
  no_out_first_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !out_valid);

  // R2
  wake_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && in_valid && in_ready) |=> !sleep);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == NW'(DEPTH)) |-> !in_ready);

  // R10
  no_sleep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0) |-> !sleep);
endmodule

bind sb_wake_ctrl sb_wake_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep     (sleep),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .q_cnt     (q_cnt)
);

// File: tb/sb_wake_ctrl_test.sv
module sb_wake_ctrl_test;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_wake, cfg_hold;
  logic          wake_done, in_valid, out_ready;
  logic [DW-1:0] in_data;
  logic          in_ready, out_valid, sleep;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sb_wake_ctrl #(.DW(DW), .DEPTH(4), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wake(cfg_wake), .cfg_hold(cfg_hold),
    .wake_done(wake_done), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sleep(sleep)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge after the accepting edge
  task automatic send_one(input logic [DW-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(input int exp_k, input logic [DW-1:0] exp_d, input string req);
    int k = 1;
    while (!out_valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k == exp_k, req, k, exp_k);
    chk(out_data == exp_d, {req, " data"}, out_data, exp_d);
  endtask

  task automatic wait_sleep(input int exp_k, input string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sleep && k < 100);
    chk(k == exp_k, req, k, exp_k);
  endtask

  task automatic t_reset();
    chk(sleep == 1'b1, "R1 sleep", sleep, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_basic();
    cfg_wake = 8'd3;
    cfg_hold = 8'd4;
    send_one(8'hA1);
    chk(sleep == 1'b0, "R2 wake start", sleep, 0);
    wait_out(4, 8'hA1, "R3 wake delay");
    wait_sleep(5, "R6 hold window");
  endtask

  task automatic t_wake_done();
    cfg_wake = 8'd20;
    cfg_hold = 8'd2;
    send_one(8'hB2);
    wake_done = 1'b1;
    @(negedge clk);
    wake_done = 1'b0;
    chk(out_valid == 1'b1, "R4 early wake", out_valid, 1);
    chk(out_data == 8'hB2, "R4 data", out_data, 8'hB2);
    wait_sleep(3, "R6 after early wake");
  endtask

  task automatic t_zero_wake();
    cfg_wake = 8'd0;
    cfg_hold = 8'd0;
    send_one(8'hC3);
    wait_out(2, 8'hC3, "R3 zero wake");
    wait_sleep(2, "R6 zero hold");
  endtask

  task automatic t_restart();
    cfg_wake = 8'd2;
    cfg_hold = 8'd6;
    send_one(8'hD4);
    wait_out(3, 8'hD4, "R3 short wake");
    repeat (3) @(negedge clk);
    chk(sleep == 1'b0, "R7 still awake", sleep, 0);
    send_one(8'hD5);
    chk(sleep == 1'b0, "R7 no new sleep", sleep, 0);
    wait_out(1, 8'hD5, "R7 direct offer");
    wait_sleep(7, "R7 window restarted");
  endtask

  task automatic t_burst();
    logic [DW-1:0] items [5];
    int got = 0;
    bit acc;
    bit busy_ok = 1'b1;
    for (int i = 0; i < 5; i++) items[i] = DW'(8'h11 + i);
    cfg_wake  = 8'd6;
    cfg_hold  = 8'd3;
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(in_ready == 1'b1, "R9 room left", in_ready, 1);
      in_valid = 1'b1;
      in_data  = items[i];
      @(negedge clk);
    end
    in_data = items[4];
    chk(in_ready == 1'b0, "R9 full stall", in_ready, 0);
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (sleep || in_ready) busy_ok = 1'b0;
    end
    chk(busy_ok, "R10 stay awake while queued", sleep, 0);
    chk(out_valid == 1'b1, "R11 held offer", out_valid, 1);
    chk(out_data == items[0], "R11 held data", out_data, items[0]);
    out_ready = 1'b1;
    for (int t = 0; t < 20 && got < 5; t++) begin
      acc = in_valid && in_ready;
      if (out_valid) begin
        chk(out_data == items[got], "R8 order", out_data, items[got]);
        got++;
      end
      if (got < 5) begin
        @(negedge clk);
        if (acc) in_valid = 1'b0;
      end
    end
    chk(got == 5, "R9 stalled request delivered", got, 5);
    wait_sleep(4, "R6 after burst");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cfg_wake  = 8'd3;
    cfg_hold  = 8'd4;
    wake_done = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wake_done();
    t_zero_wake();
    t_restart();
    t_burst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule